// File: doc/BRIEF.md
# Late-Write Pipelined Burst SRAM Core

A synchronous static memory core that samples one command on every rising clock edge. A chip-select (active low), two polarity-matched enables, an advance strobe, a write strobe (active low) and per-byte write enables (active low) are decoded into bank deselect, deselect, read, write, and a continue of whichever operation came before. Reads are pipelined: the word for a read command is driven one clock after the command is taken. Writes are double-late: the write data for a command is taken from the input bus on the second edge after the command.

A read or write that loads an external address can be followed by continue commands that step through four consecutive words. The step changes only the two low address bits, so a burst stays inside a four-word aligned block and the fourth continue returns to the loaded address. The data bus is split into an input and an output with an output enable. An echo strobe marks the slots that carry read data and has its own output enable. That enable drops only after a bank deselect. A read that follows a write to the same word before that write has reached the array takes the pending bytes from the write path.

Top module: `lwb_sram_core`

## Requirements
- R1: The two enables count as matched only when `en2` equals parameter `POL2` and `en3` equals parameter `POL3`. A non-continue command with either enable mismatched is a bank deselect, whatever `en1_n` and `we_n` are.
- R2: A non-continue command with matched enables decodes as follows. `en1_n`=1 is a deselect. `en1_n`=0 with `we_n`=1 is a read of `addr`. `en1_n`=0 with `we_n`=0 is a write to `addr`.
- R3: With `adv`=1 the previous operation type is repeated, and `en1_n`, `en2`, `en3`, `we_n` and `addr` are ignored. A continue of a deselect or bank deselect stays in that state and writes nothing.
- R4: For a read or read continue taken at edge k, `dq_out` carries the addressed word and `dq_oe`=1 after edge k+1.
- R5: For a write or write continue taken at edge k, `dq_in` is stored at edge k+2. Only byte lanes b whose `be_n[b]` was 0 at edge k are stored, and lane b is bits [8b+7:8b].
- R6: A write or write continue with all `be_n` bits 1 stores nothing, but it still loads or advances the burst address.
- R7: Each read or write continue adds one modulo 4 to address bits [1:0] and keeps the upper address bits. The fourth continue returns to the loaded address.
- R8: `dq_oe` is 0 after edge k+1 for a bank deselect, deselect or write taken at edge k.
- R9: `echo_oe` is 0 after edge k+1 only for a bank deselect taken at edge k, and is 1 for every other operation. `echo_out` is 1 exactly in the slots where read data is driven.
- R10: A read taken one edge after a write to the same word returns the bytes that write enabled, taken from `dq_in`, merged with the stored bytes it did not enable.
- R11: While reset is asserted, `dq_oe` and `echo_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en1_n | input | 1 | Chip select, active low |
| en2 | input | 1 | Enable compared against POL2 |
| en3 | input | 1 | Enable compared against POL3 |
| adv | input | 1 | 1 = continue previous operation, 0 = new command |
| we_n | input | 1 | 0 = write, 1 = read (new commands only) |
| be_n | input | NB | Byte write enables, active low |
| addr | input | AW | Word address for new commands |
| dq_in | input | NB*BW | Write data, taken two edges after its command |
| dq_out | output | NB*BW | Read data |
| dq_oe | output | 1 | Output enable for dq_out |
| echo_out | output | 1 | High while dq_out carries read data |
| echo_oe | output | 1 | Output enable for echo_out |

## Verification
A command presented before edge k has its output effect (read data, `dq_oe`, `echo_out`, `echo_oe`) visible after edge k+1. Its write data must be on `dq_in` for edge k+2. Every bench task advances one clock per command and samples at the falling edge. An output check is therefore made one task call after the command it concerns, and write data is placed two calls after its write. Burst sequences read back one word per call, ending with the wrapped fifth beat. The bypass test places the write data in the same slot in which the dependent read reaches the array.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic [1:0] {
    OP_BDES = 2'd0,
    OP_DES  = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } lwb_op_e;
endpackage

// File: rtl/lwb_cmd_decode.sv
module lwb_cmd_decode
  import lwb_pkg::*;
#(
  parameter int AW   = 6,
  parameter int NB   = 4,
  parameter bit POL2 = 1'b1,
  parameter bit POL3 = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3,
  input  logic          adv,
  input  logic          we_n,
  input  logic [NB-1:0] be_n,
  input  logic [AW-1:0] addr,
  output lwb_op_e       cur_op,
  output lwb_op_e       prev_op,
  output logic [AW-1:0] cmd_addr,
  output logic [NB-1:0] wr_mask
);
  localparam int BA = 2;

  lwb_op_e       op_q, op_d;
  logic [AW-1:0] base_q;
  logic [BA-1:0] cnt_q, cnt_d;
  logic          base_en;
  logic          en_match;

  always_comb begin
    en_match = (en2 == POL2) && (en3 == POL3);
    op_d     = op_q;
    cnt_d    = cnt_q;
    base_en  = 1'b0;
    cmd_addr = addr;
    if (!adv) begin
      base_en = 1'b1;
      cnt_d   = '0;
      if (!en_match)  op_d = OP_BDES;
      else if (en1_n) op_d = OP_DES;
      else if (we_n)  op_d = OP_RD;
      else            op_d = OP_WR;
    end else begin
      if (op_q == OP_RD || op_q == OP_WR) cnt_d = cnt_q + 1'b1;
      cmd_addr = {base_q[AW-1:BA], base_q[BA-1:0] + cnt_d};
    end
    wr_mask = (op_d == OP_WR) ? ~be_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_BDES;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      op_q  <= op_d;
      cnt_q <= cnt_d;
      if (base_en) base_q <= addr;
    end
  end

  assign cur_op  = op_d;
  assign prev_op = op_q;
endmodule

// File: rtl/lwb_array.sv
module lwb_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic [NB-1:0]    we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*BW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[b]) mem[waddr] <= wdata[b*BW +: BW];
    end
    assign rdata[b*BW +: BW] = mem[raddr];
  end
endmodule

// File: rtl/lwb_data_pipe.sv
module lwb_data_pipe
  import lwb_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lwb_op_e          cur_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [NB-1:0]    wr_mask,
  input  logic [NB*BW-1:0] dq_in,
  input  logic [NB*BW-1:0] arr_rdata,
  output logic [AW-1:0]    arr_raddr,
  output logic [NB-1:0]    arr_we,
  output logic [AW-1:0]    arr_waddr,
  output logic [NB*BW-1:0] arr_wdata,
  output logic [NB*BW-1:0] dq_out,
  output logic             dq_oe,
  output logic             echo_out,
  output logic             echo_oe
);
  localparam int DW = NB * BW;

  lwb_op_e       a_op;
  logic [AW-1:0] a_addr, b_addr;
  logic [NB-1:0] a_mask, b_mask;
  logic [DW-1:0] rd_word;
  logic          a_is_rd;
  logic          same_word;

  always_comb begin
    a_is_rd   = (a_op == OP_RD);
    same_word = (b_addr == a_addr);
  end

  for (genvar b = 0; b < NB; b++) begin : g_byp
    assign rd_word[b*BW +: BW] = (same_word && b_mask[b]) ? dq_in[b*BW +: BW]
                                                          : arr_rdata[b*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_op   <= OP_BDES;
      a_addr <= '0;
      a_mask <= '0;
      b_addr <= '0;
      b_mask <= '0;
    end else begin
      a_op   <= cur_op;
      a_addr <= cmd_addr;
      a_mask <= wr_mask;
      b_addr <= a_addr;
      b_mask <= a_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      echo_out <= 1'b0;
      echo_oe  <= 1'b0;
    end else begin
      if (a_is_rd) dq_out <= rd_word;
      dq_oe    <= a_is_rd;
      echo_out <= a_is_rd;
      echo_oe  <= (a_op != OP_BDES);
    end
  end

  assign arr_raddr = a_addr;
  assign arr_we    = b_mask;
  assign arr_waddr = b_addr;
  assign arr_wdata = dq_in;
endmodule

// File: rtl/lwb_sram_core.sv
module lwb_sram_core
  import lwb_pkg::*;
#(
  parameter int AW   = 6,
  parameter int NB   = 4,
  parameter int BW   = 8,
  parameter bit POL2 = 1'b1,
  parameter bit POL3 = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3,
  input  logic             adv,
  input  logic             we_n,
  input  logic [NB-1:0]    be_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] dq_in,
  output logic [NB*BW-1:0] dq_out,
  output logic             dq_oe,
  output logic             echo_out,
  output logic             echo_oe
);
  localparam int DW = NB * BW;

  logic [1:0]    rst_sync;
  logic          rst_n_i;
  lwb_op_e       cur_op, prev_op;
  logic [AW-1:0] cmd_addr, arr_raddr, arr_waddr;
  logic [NB-1:0] wr_mask, arr_we;
  logic [DW-1:0] arr_rdata, arr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  lwb_cmd_decode #(.AW(AW), .NB(NB), .POL2(POL2), .POL3(POL3)) u_dec (
    .clk(clk), .rst_n(rst_n_i), .en1_n(en1_n), .en2(en2), .en3(en3),
    .adv(adv), .we_n(we_n), .be_n(be_n), .addr(addr),
    .cur_op(cur_op), .prev_op(prev_op), .cmd_addr(cmd_addr), .wr_mask(wr_mask)
  );

  lwb_data_pipe #(.AW(AW), .NB(NB), .BW(BW)) u_pipe (
    .clk(clk), .rst_n(rst_n_i), .cur_op(cur_op), .cmd_addr(cmd_addr),
    .wr_mask(wr_mask), .dq_in(dq_in), .arr_rdata(arr_rdata),
    .arr_raddr(arr_raddr), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .dq_out(dq_out), .dq_oe(dq_oe),
    .echo_out(echo_out), .echo_oe(echo_oe)
  );

  lwb_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );
endmodule

// File: rtl/lwb_chk.sv
module lwb_chk
  import lwb_pkg::*;
#(
  parameter int AW   = 6,
  parameter bit POL2 = 1'b1,
  parameter bit POL3 = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en1_n,
  input logic          en2,
  input logic          en3,
  input logic          adv,
  input logic          we_n,
  input lwb_op_e       prev_op,
  input logic [AW-1:0] cmd_addr,
  input logic          dq_oe,
  input logic          echo_out,
  input logic          echo_oe
);
  logic en_match;
  assign en_match = (en2 == POL2) && (en3 == POL3);

  // R1 / R9: bank deselect drops the echo enable two edges on
  assert_bdes_echo_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !en_match) |-> ##2 (!echo_oe && !dq_oe));

  // R9 / R2: a deselect keeps the echo driven but not the data
  assert_des_echo_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && en_match && en1_n) |-> ##2 (echo_oe && !dq_oe));

  // R8: write command leaves the data output undriven
  assert_write_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && en_match && !en1_n && !we_n) |-> ##2 !dq_oe);

  // R4: read command drives data and echo
  assert_read_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && en_match && !en1_n && we_n) |-> ##2 (dq_oe && echo_out));

  // R7: transfer continue steps low bits, keeps upper bits
  assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (prev_op == OP_RD || prev_op == OP_WR)) |->
      ((cmd_addr[1:0] == $past(cmd_addr[1:0]) + 2'd1) &&
       (cmd_addr[AW-1:2] == $past(cmd_addr[AW-1:2]))));

  // R3: continue repeats the previous operation
  assert_cont_keeps_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (prev_op == $past(prev_op)));

  // R9: driven data implies driven echo
  assert_oe_needs_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> echo_oe);
endmodule

bind lwb_sram_core lwb_chk #(.AW(AW), .POL2(POL2), .POL3(POL3)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .en1_n(en1_n), .en2(en2), .en3(en3),
  .adv(adv), .we_n(we_n), .prev_op(prev_op), .cmd_addr(cmd_addr),
  .dq_oe(dq_oe), .echo_out(echo_out), .echo_oe(echo_oe)
);

// File: tb/tb_lwb_sram_core.sv
module tb_lwb_sram_core;
  logic        clk;
  logic        rst_n;
  logic        en1_n, en2, en3, adv, we_n;
  logic [3:0]  be_n;
  logic [5:0]  addr;
  logic [31:0] dq_in;
  logic [31:0] dq_out;
  logic        dq_oe, echo_out, echo_oe;

  int checks;
  int failures;
  bit finished;

  lwb_sram_core dut (
    .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3(en3),
    .adv(adv), .we_n(we_n), .be_n(be_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .echo_out(echo_out), .echo_oe(echo_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one command per clock; returns at the falling edge after it is taken
  task automatic step(input logic a_v, input logic e1n, input logic e2v, input logic e3v,
                      input logic wn, input logic [3:0] bn, input logic [5:0] ad,
                      input logic [31:0] d);
    adv = a_v; en1_n = e1n; en2 = e2v; en3 = e3v; we_n = wn;
    be_n = bn; addr = ad; dq_in = d;
    @(negedge clk);
  endtask

  task automatic t_rd(input logic [5:0] ad, input logic [31:0] d);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, ad, d);
  endtask
  task automatic t_wr(input logic [5:0] ad, input logic [3:0] bn, input logic [31:0] d);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, bn, ad, d);
  endtask
  task automatic t_des(input logic [31:0] d);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd0, d);
  endtask
  task automatic t_bdes(input logic [31:0] d);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, d);
  endtask
  // continue with a write-looking command on the ignored pins (R3)
  task automatic t_cont(input logic [3:0] bn, input logic [31:0] d);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, bn, 6'd5, d);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    t_des(32'h0);
    t_des(32'h0);
    check("R11 dq_oe in reset", {31'd0, dq_oe}, 32'd0);
    check("R11 echo_oe in reset", {31'd0, echo_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) t_des(32'h0);
  endtask

  task automatic test_single;
    t_wr(6'd5, 4'h0, 32'h0);
    t_des(32'h0);
    t_des(32'h1234_5678);
    t_rd(6'd5, 32'h0);
    t_wr(6'd7, 4'h0, 32'h0);
    check("R4 read data", dq_out, 32'h1234_5678);
    check("R4 read oe", {31'd0, dq_oe}, 32'd1);
    check("R9 echo with read", {31'd0, echo_out}, 32'd1);
    t_des(32'h0);
    check("R8 oe after write", {31'd0, dq_oe}, 32'd0);
    check("R9 echo oe after write", {31'd0, echo_oe}, 32'd1);
    t_des(32'h0777_0777);
  endtask

  task automatic test_bytes;
    t_wr(6'd6, 4'h0, 32'h0);
    t_des(32'h0);
    t_des(32'hAAAA_AAAA);
    t_wr(6'd6, 4'b1010, 32'h0);
    t_des(32'h0);
    t_des(32'h1122_3344);
    t_rd(6'd6, 32'h0);
    t_des(32'h0);
    check("R5 byte mask", dq_out, 32'hAA22_AA44);
    t_wr(6'd6, 4'hF, 32'h0);
    t_des(32'h0);
    t_des(32'hDEAD_BEEF);
    t_rd(6'd6, 32'h0);
    t_des(32'h0);
    check("R6 abort stores nothing", dq_out, 32'hAA22_AA44);
  endtask

  task automatic test_burst;
    t_wr(6'd10, 4'h0, 32'h0);
    t_des(32'h0);
    t_des(32'h5A5A_5A5A);
    t_wr(6'd9, 4'h0, 32'h0);
    t_cont(4'hF, 32'h0);
    t_cont(4'h0, 32'hD000_0000);
    t_cont(4'h0, 32'hC0FF_EE00);
    t_des(32'hD000_0002);
    t_des(32'hD000_0003);
    t_rd(6'd9, 32'h0);
    t_cont(4'h0, 32'h0);
    check("R7 beat0 addr9", dq_out, 32'hD000_0000);
    t_cont(4'h0, 32'h0);
    check("R6 aborted beat addr10", dq_out, 32'h5A5A_5A5A);
    t_cont(4'h0, 32'h0);
    check("R7 beat2 addr11", dq_out, 32'hD000_0002);
    t_cont(4'h0, 32'h0);
    check("R7 beat3 wraps to addr8", dq_out, 32'hD000_0003);
    t_des(32'h0);
    check("R7 fourth continue back to base", dq_out, 32'hD000_0000);
    t_des(32'h0);
    check("R8 oe after deselect", {31'd0, dq_oe}, 32'd0);
    check("R9 echo oe after deselect", {31'd0, echo_oe}, 32'd1);
  endtask

  task automatic test_bypass;
    t_wr(6'd20, 4'h0, 32'h0);
    t_rd(6'd20, 32'h0);
    t_des(32'hB1B1_B1B1);
    check("R10 full bypass", dq_out, 32'hB1B1_B1B1);
    t_wr(6'd20, 4'b0011, 32'h0);
    t_rd(6'd20, 32'h0);
    t_des(32'h2222_2222);
    check("R10 partial bypass", dq_out, 32'h2222_B1B1);
    t_rd(6'd20, 32'h0);
    t_des(32'h0);
    check("R5 bypassed write landed", dq_out, 32'h2222_B1B1);
  endtask

  task automatic test_deselect_cont;
    t_des(32'h0);
    t_cont(4'h0, 32'h0);
    check("R3 deselect continue echo oe", {31'd0, echo_oe}, 32'd1);
    t_des(32'hFFFF_FFFF);
    check("R3 deselect continue no drive", {31'd0, dq_oe}, 32'd0);
    t_des(32'hFFFF_FFFF);
    t_rd(6'd5, 32'h0);
    t_des(32'h0);
    check("R3 continue wrote nothing", dq_out, 32'h1234_5678);
  endtask

  task automatic test_bank;
    t_rd(6'd5, 32'h0);
    t_bdes(32'h0);
    check("R9 bank deselect one cycle late", {30'd0, dq_oe, echo_oe}, 32'd3);
    t_cont(4'h0, 32'h0);
    check("R9 echo off after bank deselect", {30'd0, dq_oe, echo_oe}, 32'd0);
    t_des(32'h0);
    check("R3 bank deselect continue stays", {31'd0, echo_oe}, 32'd0);
    t_des(32'h0);
    check("R2 deselect restores echo", {31'd0, echo_oe}, 32'd1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0);
    t_des(32'h0);
    check("R1 en3 mismatch is bank deselect", {30'd0, dq_oe, echo_oe}, 32'd0);
    t_des(32'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 6'd5, 32'h0);
    t_des(32'h0);
    check("R1 en2 mismatch is bank deselect", {30'd0, dq_oe, echo_oe}, 32'd0);
    t_des(32'h9999_9999);
    t_rd(6'd5, 32'h0);
    t_des(32'h0);
    check("R1 mismatched write stored nothing", dq_out, 32'h1234_5678);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    test_reset;
    test_single;
    test_bytes;
    test_burst;
    test_bypass;
    test_deselect_cont;
    test_bank;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule